// File: doc/BRIEF.md
# IR Carrier Period and Duty Meter

This block measures the carrier of a modulated infrared signal. It samples the raw IR line on a 2 MHz timebase strobe, so every count is in 500 ns units. On each rising edge of the sampled line it closes one carrier cycle. The cycle's length is its period count, and the number of high samples inside it is its high count. Software gets the carrier frequency as 2,000,000 / period and the duty in percent as high × 100 / period.

A result is only captured once the carrier has run without a break for a programmable number of cycles. The captured pair then stays frozen behind a valid flag until software reads the period register. This keeps the two counts consistent with each other while they are read. Detection runs only while the enable input is high. A run-length threshold, written with 0x63 in normal use, filters out stray edges.

Top module: `ir_carrier_meter`

## Requirements
- R1: After reset, per_o and high_o both read 0.
- R2: per_o[7] is the valid flag and per_o[6:0] is the period: the number of timebase ticks from one sampled rising edge of ir_i to the next.
- R3: high_o[6:0] is the number of ticks in that same cycle at which ir_i was sampled high, and high_o[7] reads 0.
- R4: A cycle is captured only once the run of consecutive good cycles reaches the threshold. The threshold is the byte last written through thr_wr_i/thr_wdata_i. A threshold of 0 or 1 captures the first good cycle. The first rising edge after enable only opens a cycle and is never itself good.
- R5: The internal counts saturate at 127 and never wrap. A cycle that reaches 127 ticks is not a good cycle: it is not reported and it restarts the run. The longest reportable period is 126.
- R6: While valid is set, per_o and high_o do not change, whatever the IR input does, until a read.
- R7: A one-cycle pulse on per_rd_i clears the valid flag from the next cycle on. The period and high bits keep their values.
- R8: While det_en_i is low, nothing is captured and the run of good cycles is reset.
- R9: ir_i is sampled only in cycles where tick_i is high. Changes between ticks have no effect.
- R10: Whenever valid is set, the period is nonzero and the high count does not exceed it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | 2 MHz timebase strobe, one clock wide |
| ir_i | input | 1 | Raw modulated IR input, synchronous to clk |
| det_en_i | input | 1 | Carrier detection enable |
| thr_wr_i | input | 1 | Write strobe for the run-length threshold |
| thr_wdata_i | input | 8 | Threshold value |
| per_rd_i | input | 1 | Read strobe for the period register; clears valid |
| per_o | output | 8 | {valid, period[6:0]} |
| high_o | output | 8 | {1'b0, high[6:0]} |

## Verification
A period or high counter that starts one tick off shows up in the very first captured result, as a count off by one against the cycle shape that was driven. An error in the run counter moves the cycle at which valid rises, so the sweep checks valid to be low exactly one rising edge before it must go high. A saturation fault shows up as a small wrapped period after a 127-tick cycle. A freeze or clear fault shows up as a changed value while valid is set, or as a flag that is still set after a read.

// File: rtl/ir_carrier_meter.sv
module ir_carrier_meter #(
  parameter int CW = 7,
  parameter int RW = 8,
  parameter logic [RW-1:0] THR_RST = RW'(1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          ir_i,
  input  logic          det_en_i,
  input  logic          thr_wr_i,
  input  logic [RW-1:0] thr_wdata_i,
  input  logic          per_rd_i,
  output logic [CW:0]   per_o,
  output logic [CW:0]   high_o
);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [RW-1:0] RMAX = '1;

  logic          ir_q;
  logic [CW-1:0] per_cnt, hi_cnt, per_q, hi_q;
  logic [RW-1:0] run, thr_q;
  logic          vld_q;

  wire           rise   = tick_i & det_en_i & ir_i & ~ir_q;
  wire           good   = per_cnt != CMAX;
  wire [RW-1:0]  run_nx = !good ? '0 : (run == RMAX ? run : run + RW'(1));
  wire           take   = rise & good & (run_nx >= thr_q) & ~vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ir_q    <= 1'b0;
      per_cnt <= CMAX;
      hi_cnt  <= '0;
      run     <= '0;
      thr_q   <= THR_RST;
      per_q   <= '0;
      hi_q    <= '0;
      vld_q   <= 1'b0;
    end else begin
      if (thr_wr_i) thr_q <= thr_wdata_i;
      if (!det_en_i) begin
        ir_q    <= 1'b0;
        per_cnt <= CMAX;
        hi_cnt  <= '0;
        run     <= '0;
      end else if (tick_i) begin
        ir_q <= ir_i;
        if (rise) begin
          per_cnt <= CW'(1);
          hi_cnt  <= CW'(1);
          run     <= run_nx;
        end else begin
          if (per_cnt != CMAX) per_cnt <= per_cnt + CW'(1);
          else                 run     <= '0;
          if (ir_i && hi_cnt != CMAX) hi_cnt <= hi_cnt + CW'(1);
        end
      end
      if (take) begin
        per_q <= per_cnt;
        hi_q  <= hi_cnt;
      end
      if (take)          vld_q <= 1'b1;
      else if (per_rd_i) vld_q <= 1'b0;
    end
  end

  assign per_o  = {vld_q, per_q};
  assign high_o = {1'b0, hi_q};

  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    per_o[CW] && !per_rd_i |=> $stable(per_o) && $stable(high_o));
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    per_rd_i && per_o[CW] |=> !per_o[CW]);
  p_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en_i && !per_o[CW] |=> !per_o[CW]);
  p_no_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i && !per_rd_i |=> $stable(per_o) && $stable(high_o));
  p_sane_r10: assert property (@(posedge clk) disable iff (!rst_n)
    per_o[CW] |-> (per_o[CW-1:0] != '0) && (high_o[CW-1:0] <= per_o[CW-1:0]));
endmodule

// File: tb/test_ir_carrier_meter.sv
module test_ir_carrier_meter;
  logic clk = 0, rst_n = 0, tick = 0, ir = 0, en = 0, thr_wr = 0, rd = 0;
  logic [7:0] thr_d = 0;
  logic [7:0] per, high;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ir_carrier_meter i_ir_carrier_meter (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .ir_i(ir), .det_en_i(en),
    .thr_wr_i(thr_wr), .thr_wdata_i(thr_d), .per_rd_i(rd),
    .per_o(per), .high_o(high));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step(input logic v);
    @(negedge clk); ir = v; tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic cyc(input int p, input int h);
    for (int i = 0; i < p; i++) step(i < h);
  endtask

  task automatic rdp();
    @(negedge clk); rd = 1;
    @(negedge clk); rd = 0;
  endtask

  task automatic set_thr(input logic [7:0] t);
    @(negedge clk); thr_wr = 1; thr_d = t;
    @(negedge clk); thr_wr = 0;
  endtask

  task automatic restart();
    @(negedge clk); en = 0;
    @(negedge clk); en = 1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 period", per, 8'h00);
    chk("R1 high", high, 8'h00);

    // R2 R3 R4: sweep of period/high shapes, threshold 3
    set_thr(8'd3);
    for (int p = 2; p <= 20; p++)
      for (int h = 1; h < p; h++) begin
        restart();
        cyc(p, h); cyc(p, h); cyc(p, h);
        chk("R4 early", {7'd0, per[7]}, 8'd0);
        step(1);
        chk("R2 period", per, {1'b1, 7'(p)});
        chk("R3 high", high, {1'b0, 7'(h)});
        rdp();
        chk("R7 cleared", per, {1'b0, 7'(p)});
      end

    // R4: threshold 0 captures first good cycle
    set_thr(8'd0);
    restart(); cyc(6, 3);
    chk("R4 thr0 first edge", {7'd0, per[7]}, 8'd0);
    step(1);
    chk("R4 thr0", per, 8'h86);
    rdp();

    // R4: threshold 0x63
    set_thr(8'h63);
    restart();
    for (int i = 0; i < 99; i++) cyc(4, 2);
    chk("R4 thr99 early", {7'd0, per[7]}, 8'd0);
    step(1);
    chk("R4 thr99", per, 8'h84);
    chk("R4 thr99 high", high, 8'h02);
    rdp();

    // R5: longest reportable period
    set_thr(8'd1);
    restart(); cyc(126, 125); step(1);
    chk("R5 period 126", per, {1'b1, 7'd126});
    chk("R5 high 125", high, {1'b0, 7'd125});
    rdp();

    // R5: 127-tick cycles rejected, no wrap, run recovers
    restart(); cyc(127, 1); cyc(127, 1); step(1);
    chk("R5 sat rejected", {7'd0, per[7]}, 8'd0);
    cyc(200, 0); step(1);
    chk("R5 long gap", {7'd0, per[7]}, 8'd0);
    step(1); step(0); step(0); step(0); step(1);
    chk("R5 recover period", per, 8'h85);
    chk("R5 recover high", high, 8'h02);

    // R6: frozen while valid
    cyc(8, 3); cyc(8, 3);
    chk("R6 frozen period", per, 8'h85);
    chk("R6 frozen high", high, 8'h02);
    rdp();
    chk("R7 clear keeps data", per, 8'h05);
    step(1);
    chk("R6 next capture", per, 8'h88);
    chk("R6 next high", high, 8'h03);
    rdp();

    // R8: disabled
    @(negedge clk); en = 0;
    for (int i = 0; i < 5; i++) cyc(6, 3);
    step(1);
    chk("R8 disabled", per, 8'h08);
    @(negedge clk); en = 1;
    cyc(6, 3);
    chk("R8 run reset", {7'd0, per[7]}, 8'd0);

    // R9: changes between ticks ignored
    restart(); cyc(10, 5);
    @(negedge clk); ir = 1;
    repeat (3) @(negedge clk);
    ir = 0;
    repeat (3) @(negedge clk);
    chk("R9 no capture", {7'd0, per[7]}, 8'd0);
    step(1);
    chk("R9 period", per, 8'h8a);
    chk("R9 high", high, 8'h05);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule